// File: doc/BRIEF.md
# Double-Buffered Scanned LED Tile

This block models one monochrome LED tile of 64 columns by 32 rows that is driven with 1/16 row scanning. The tile has an upper half and a lower half of 16 rows each. The same row number is lit in both halves at once. Each half has eight byte-wide column registers, so a byte written over a parallel bus lands in one of sixteen first-stage registers picked by a 4-bit index.

A single transfer strobe copies all sixteen first-stage bytes at once into a second stage. Only the second stage drives the column outputs. The host can therefore load the next row while the current one stays steady, and no ghost image appears.

Tiles are cascaded side by side through an enable vector. A tile accepts writes only when bit 0 of the vector it receives is high. It hands the vector to its right-hand neighbour rotated by one place. Identical tiles therefore answer to successive enable lines, and a chain of tiles looks like one contiguous row of byte registers.

Top module: `ledtile_top`

## Requirements
- R1: After reset, every first- and second-stage byte is zero and `row_sel` equals 16'h0001, which selects row 0.
- R2: On a rising clock edge where `wr_en` is 1 and `sel_in[0]` is 1, the first-stage byte numbered `wr_idx` takes `wr_data`. The byte is seen on the columns only after a later transfer.
- R3: A write is ignored when `wr_en` is 0, or when `sel_in[0]` is 0, whatever the other `sel_in` bits are. The next transfer shows the earlier contents unchanged.
- R4: Indices 0 to 7 feed the upper half and indices 8 to 15 feed the lower half. Index k (or k+8) covers columns 8k to 8k+7 of its half.
- R5: Column c of a half (0 is leftmost) appears on output bit 63-c. Bit 7 of a byte is its leftmost pixel, and a 1 lights the pixel.
- R6: On a rising edge with `xfer` at 1, all sixteen first-stage bytes move into the second stage together. Without `xfer`, `upper_cols` and `lower_cols` stay constant even while writes happen.
- R7: When a write and `xfer` fall on the same edge, the second stage receives the first-stage contents from before that write. The new byte stays in the first stage for the next transfer.
- R8: `row_sel` is one-hot, with bit r lighting row r. It takes the value of `row_code` only on an edge with `xfer` at 1. Changes of `row_code` at other times have no effect.
- R9: `sel_out[i]` equals `sel_in[(i+1) mod SEL_W]` combinationally, so bit 1 of the incoming vector becomes bit 0 for the next tile.
- R10: A transfer leaves the first stage unchanged, so two transfers with no write between them show the same columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_in | input | SEL_W | Tile enable vector; bit 0 enables this tile |
| sel_out | output | SEL_W | Enable vector rotated for the next tile |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | First-stage byte index |
| wr_data | input | 8 | Byte to write |
| xfer | input | 1 | Transfer strobe, first stage to second stage, also loads row |
| row_code | input | 4 | Row number taken on transfer |
| row_sel | output | 16 | One-hot active row, shared by both halves |
| upper_cols | output | 64 | Upper-half column drive, column 0 at bit 63 |
| lower_cols | output | 64 | Lower-half column drive, column 0 at bit 63 |

## Verification
Two things can land on the same edge: a byte write into the first stage and the transfer that copies the first stage out. The bench forces this by raising `xfer` together with an enabled write, first to a byte whose old value is known and later at random. The scoreboard model applies the transfer using the first-stage contents from before the write, and only then applies the write. The columns after that edge must show the old byte, and the next transfer with no write between must show the new one.

// File: rtl/ledtile_pkg.sv
package ledtile_pkg;

  localparam int BYTE_W = 8;

  // Least significant output bit of byte lane k in a half of `cols` columns,
  // with column 0 sitting at the most significant bit.
  function automatic int byte_lane_lsb(input int k, input int cols);
    return cols - BYTE_W * (k + 1);
  endfunction

endpackage

// File: rtl/ledtile_sel_chain.sv
module ledtile_sel_chain #(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_out,
  output logic             own_sel
);

  assign own_sel = sel_in[0];

  for (genvar i = 0; i < SEL_W; i++) begin : g_rot
    assign sel_out[i] = sel_in[(i + 1) % SEL_W];
  end

  // R9: rotation neither creates nor drops enable lines
  always_comb begin
    assert_rot_keeps_count_R9: assert ($countones(sel_out) == $countones(sel_in));
  end

endmodule

// File: rtl/ledtile_wr_bank.sv
module ledtile_wr_bank #(
  parameter int NUM_LATCH = 16,
  parameter int BYTE_W    = 8,
  localparam int IDX_W    = $clog2(NUM_LATCH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_fire,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [BYTE_W-1:0]                wr_data,
  output logic [NUM_LATCH-1:0][BYTE_W-1:0] bank_q
);

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_byte
    logic hit;
    assign hit = wr_fire && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[i] <= '0;
      else if (hit) bank_q[i] <= wr_data;
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> bank_q[$past(wr_idx)] == $past(wr_data));

  assert_idle_bank_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(bank_q));

endmodule

// File: rtl/ledtile_show_reg.sv
module ledtile_show_reg #(
  parameter int COLS      = 64,
  parameter int ROWS_HALF = 16,
  parameter int BYTE_W    = 8,
  localparam int LATCH_HALF = COLS / BYTE_W,
  localparam int NUM_LATCH  = 2 * LATCH_HALF,
  localparam int ROW_W      = $clog2(ROWS_HALF)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             xfer,
  input  logic [NUM_LATCH-1:0][BYTE_W-1:0] bank_q,
  input  logic [ROW_W-1:0]                 row_code,
  output logic [COLS-1:0]                  upper_cols,
  output logic [COLS-1:0]                  lower_cols,
  output logic [ROWS_HALF-1:0]             row_sel
);

  logic [NUM_LATCH-1:0][BYTE_W-1:0] disp_q;
  logic [ROW_W-1:0]                 row_q;

  function automatic logic [ROWS_HALF-1:0] row_decode(input logic [ROW_W-1:0] code);
    logic [ROWS_HALF-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
      row_q  <= '0;
    end else if (xfer) begin
      disp_q <= bank_q;
      row_q  <= row_code;
    end
  end

  assign row_sel = row_decode(row_q);

  for (genvar k = 0; k < LATCH_HALF; k++) begin : g_lane
    localparam int LSB = ledtile_pkg::byte_lane_lsb(k, COLS);
    assign upper_cols[LSB +: BYTE_W] = disp_q[k];
    assign lower_cols[LSB +: BYTE_W] = disp_q[k + LATCH_HALF];
  end

  // R6 / R7: a transfer takes the first stage as it stood before the edge
  assert_xfer_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> disp_q == $past(bank_q));

  assert_cols_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(upper_cols) && $stable(lower_cols));

  assert_row_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);

  assert_row_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> row_sel[$past(row_code)]);

  assert_row_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(row_sel));

endmodule

// File: rtl/ledtile_top.sv
module ledtile_top #(
  parameter int COLS      = 64,
  parameter int ROWS_HALF = 16,
  parameter int SEL_W     = 4,
  localparam int BYTE_W     = ledtile_pkg::BYTE_W,
  localparam int LATCH_HALF = COLS / BYTE_W,
  localparam int NUM_LATCH  = 2 * LATCH_HALF,
  localparam int IDX_W      = $clog2(NUM_LATCH),
  localparam int ROW_W      = $clog2(ROWS_HALF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     sel_in,
  output logic [SEL_W-1:0]     sel_out,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic                 xfer,
  input  logic [ROW_W-1:0]     row_code,
  output logic [ROWS_HALF-1:0] row_sel,
  output logic [COLS-1:0]      upper_cols,
  output logic [COLS-1:0]      lower_cols
);

  logic                             own_sel;
  logic                             wr_fire;
  logic [NUM_LATCH-1:0][BYTE_W-1:0] bank_q;

  ledtile_sel_chain #(.SEL_W(SEL_W)) u_chain (
    .sel_in (sel_in),
    .sel_out(sel_out),
    .own_sel(own_sel)
  );

  assign wr_fire = wr_en && own_sel;

  ledtile_wr_bank #(.NUM_LATCH(NUM_LATCH), .BYTE_W(BYTE_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_fire(wr_fire),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .bank_q (bank_q)
  );

  ledtile_show_reg #(.COLS(COLS), .ROWS_HALF(ROWS_HALF), .BYTE_W(BYTE_W)) u_show (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .bank_q    (bank_q),
    .row_code  (row_code),
    .upper_cols(upper_cols),
    .lower_cols(lower_cols),
    .row_sel   (row_sel)
  );

  // R3: a deselected tile never changes its first stage
  assert_deselected_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in[0] |=> $stable(bank_q));

endmodule

// File: tb/ledtile_top_tb.sv
`timescale 1ns/1ps
module ledtile_top_tb;

  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel_in = '0;
  logic [3:0]  sel_out;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic        xfer = 1'b0;
  logic [3:0]  row_code = '0;
  logic [15:0] row_sel;
  logic [63:0] upper_cols, lower_cols;

  always #(HALF) clk = ~clk;

  ledtile_top u_dut (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .sel_out(sel_out),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .xfer(xfer),
    .row_code(row_code), .row_sel(row_sel),
    .upper_cols(upper_cols), .lower_cols(lower_cols)
  );

  typedef struct {
    logic [63:0] up;
    logic [63:0] lo;
    logic [15:0] row;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;
  logic [7:0]  m_s1 [16];
  logic [7:0]  m_s2 [16];
  logic [3:0]  m_row;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Column c of a half is output bit 63-c; bit 7 of each byte is leftmost
  function automatic logic [63:0] half_view(input int base);
    logic [63:0] v;
    for (int c = 0; c < 64; c++) v[63 - c] = m_s2[base + c / 8][7 - (c % 8)];
    return v;
  endfunction

  task automatic step(input bit we, input logic [3:0] idx, input logic [7:0] d,
                      input logic [3:0] sel, input bit x, input logic [3:0] rc,
                      input string tag);
    exp_t e;
    logic [3:0] rot;
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_data = d; sel_in = sel; xfer = x; row_code = rc;
    #0.5;
    rot = {sel[0], sel[3:1]};
    chk(sel_out == rot, "R9 sel_out rotation", {60'd0, sel_out}, {60'd0, rot});
    @(posedge clk);
    if (x) begin
      for (int i = 0; i < 16; i++) m_s2[i] = m_s1[i];
      m_row = rc;
    end
    if (we && sel[0]) m_s1[idx] = d;
    e.up = half_view(0);
    e.lo = half_view(8);
    e.row = 16'd1 << m_row;
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (mon_on && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(upper_cols == e.up, {e.tag, " upper_cols"}, upper_cols, e.up);
      chk(lower_cols == e.lo, {e.tag, " lower_cols"}, lower_cols, e.lo);
      chk(row_sel == e.row, {e.tag, " row_sel"}, {48'd0, row_sel}, {48'd0, e.row});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_s1[i] = '0; m_s2[i] = '0; end
    m_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(upper_cols == 64'd0, "R1 reset upper", upper_cols, 64'd0);
    chk(lower_cols == 64'd0, "R1 reset lower", lower_cols, 64'd0);
    chk(row_sel == 16'h0001, "R1 reset row", {48'd0, row_sel}, 64'h1);
    mon_on = 1'b1;

    // R1: first stage starts cleared; R8 row taken on transfer
    step(0, 4'd0, 8'h00, 4'b0001, 1, 4'd5, "R1 xfer after reset");

    // R2/R6: fill every byte, columns must not move until the transfer
    for (int i = 0; i < 16; i++)
      step(1, 4'(i), 8'(8'h11 * (i + 1) ^ 8'hA5), 4'b0001, 0, 4'd0, "R6 hold while loading");
    step(0, 4'd0, 8'h00, 4'b0001, 1, 4'd9, "R2 R4 full transfer");

    // R5: single pixel in byte 0 bit 7 -> upper column 0 (bit 63); byte 15 bit 0 -> lower column 63
    step(1, 4'd0, 8'h80, 4'b0001, 0, 4'd0, "R5 load");
    step(1, 4'd15, 8'h01, 4'b0001, 0, 4'd0, "R5 load");
    step(0, 4'd0, 8'h00, 4'b0001, 1, 4'd3, "R5 R4 transfer");
    @(negedge clk);
    chk(upper_cols[63] == 1'b1 && upper_cols[62:56] == 7'd0, "R5 leftmost pixel", upper_cols, 64'h80 << 56);
    chk(lower_cols[7:0] == 8'h01, "R5 lower rightmost pixel", {56'd0, lower_cols[7:0]}, 64'h01);

    // R3: ignored writes (deselected with other lines high, or strobe low)
    step(1, 4'd0, 8'hFF, 4'b1110, 0, 4'd0, "R3 deselected");
    step(0, 4'd15, 8'hFF, 4'b1111, 0, 4'd0, "R3 strobe low");
    step(0, 4'd0, 8'h00, 4'b0000, 1, 4'd3, "R3 transfer shows old");

    // R8: row code alone has no effect
    step(0, 4'd0, 8'h00, 4'b0001, 0, 4'd12, "R8 row ignored");
    step(0, 4'd0, 8'h00, 4'b0001, 0, 4'd15, "R8 row ignored");

    // R7: write and transfer on the same edge
    step(1, 4'd0, 8'h3C, 4'b0001, 1, 4'd7, "R7 collision");
    step(0, 4'd0, 8'h00, 4'b0001, 1, 4'd8, "R7 new byte next");

    // R10: transfer does not clear the first stage
    step(0, 4'd0, 8'h00, 4'b0001, 1, 4'd8, "R10 second transfer");

    // R9: a few distinct vectors
    step(0, 4'd0, 8'h00, 4'b0010, 0, 4'd0, "R9 pattern");
    step(0, 4'd0, 8'h00, 4'b1000, 0, 4'd0, "R9 pattern");
    step(0, 4'd0, 8'h00, 4'b0101, 0, 4'd0, "R9 pattern");

    // Random mix, collisions included (R2 R3 R6 R7 R8)
    for (int n = 0; n < 400; n++)
      step(1'($urandom), 4'($urandom), 8'($urandom), 4'($urandom),
           ($urandom % 4) == 0, 4'($urandom), "R7 random mix");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule